// File: doc/BRIEF.md
# Eight-Bit Waveform Timer

This block is an 8-bit timer/counter that produces one waveform on output B. A three-bit mode selects one of four counting schemes: free-running count, clear on a compare-A match, single-slope (fast) PWM, or dual-slope (phase-correct) PWM. The counting ceiling (TOP) is either the fixed value 0xFF or the value held in compare register A. A small write port loads the control fields, the two compare registers and the flag-clear register.

Each compare register has a buffer and an active copy. A write always lands in the buffer. The active copy takes the buffer value at a point that depends on the mode: at once in the non-PWM modes, at TOP in phase-correct modes, and on the TOP-to-BOTTOM wrap in fast PWM. A sticky overflow flag marks the mode-specific end of each period, and a pin-enable tells the pad when the waveform drives the pin.

Top module: `wave_timer8`

## Requirements
- R1: After reset the counter is 0x00 and counts up, every register reads as zero, and wfOut, wfOutEn and ovfFlag are low. In mode 0 the first flag appears after the 256th clock edge.
- R2: The mode is {ctrlB[0], ctrlA[1:0]}, with ctrlA at address 0 and ctrlB at address 1. The compare-output field comB is ctrlA[5:4]. Writes to ctrlA[3:2] have no effect. Reserved modes 4 and 6 behave exactly like mode 0.
- R3: In mode 0 the counter increments on every clock and wraps from 0xFF to 0x00. The flag is set on the edge at which the counter leaves 0xFF.
- R4: In mode 2 the counter returns to 0x00 on the clock after it equals compare A. The flag is set only on an edge that leaves 0xFF.
- R5: Modes 3 (TOP 0xFF) and 7 (TOP compare A) count 0 to TOP and wrap. With comB=10, wfOut clears on a compare-B match and sets on the edge leaving TOP; comB=11 does the inverse; comB=01 disconnects the pin.
- R6: Modes 1 (TOP 0xFF) and 5 (TOP compare A) count up to TOP and then down to 0x00, visiting each endpoint once per period. The flag is set on the edge at which the counter arrives at 0x00.
- R7: In modes 1 and 5 with comB=10, a compare-B match clears wfOut while the next step is upward and sets it while the next step is downward; comB=11 does the inverse. When compare B equals TOP and comB[1] is set, the match is ignored and the action (set for 10, clear for 11) happens at TOP.
- R8: Writes to compare A (address 2) and compare B (address 3) take effect at once in modes 0, 2, 4 and 6. In phase-correct modes they take effect on the edge leaving TOP; in fast PWM modes they take effect on the TOP-to-BOTTOM wrap.
- R9: ovfFlag stays set until a write to address 4 with bit 0 high clears it; writing 0 there has no effect. A set in the same cycle wins.
- R10: wfOutEn is low when comB=00, and when comB=01 in any PWM mode; otherwise it is high.
- R11: In modes 0, 2, 4 and 6 a compare-B match toggles wfOut for comB=01, clears it for 10 and sets it for 11.
- R12: In mode 7 the flag is set on the edge at which the counter leaves TOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address (0 ctrlA, 1 ctrlB, 2 compare A, 3 compare B, 4 flag clear) |
| wrData | input | 8 | Write data |
| wfOut | output | 1 | Waveform output B |
| wfOutEn | output | 1 | Drive enable for the waveform pin |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
The hardest cases to reach are compare writes that arrive mid-period in the buffered modes, where the new value must stay inert until the right endpoint. Close behind is the phase-correct case where compare B equals TOP, so the pin action must move onto the turnaround. The stimulus writes new compare values at arbitrary points within running periods of modes 1, 5 and 7. It also sets compare B equal to compare A in mode 5, and sets it to zero, so both turnaround points carry a pin action. The reference model follows each write through the buffer on every clock.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int ADDR_CTRLA = 0;
  localparam int ADDR_CTRLB = 1;
  localparam int ADDR_CMPA  = 2;
  localparam int ADDR_CMPB  = 3;
  localparam int ADDR_FLAGS = 4;

  localparam logic [2:0] MODE_NORMAL = 3'd0;
  localparam logic [2:0] MODE_PC_FF  = 3'd1;
  localparam logic [2:0] MODE_CTC    = 3'd2;
  localparam logic [2:0] MODE_FAST_FF = 3'd3;
  localparam logic [2:0] MODE_PC_A   = 3'd5;
  localparam logic [2:0] MODE_FAST_A = 3'd7;

  typedef enum logic [1:0] {CNT_INC, CNT_DEC, CNT_ZERO, CNT_HOLD} cntOp_e;
  typedef enum logic [1:0] {PIN_KEEP, PIN_SET, PIN_CLR, PIN_TGL} pinOp_e;

  typedef struct packed {
    cntOp_e cntOp;
    logic   dirNext;
    logic   immediate;
    logic   loadAct;
    logic   setFlag;
    pinOp_e pinOp;
  } wtStrobe_t;
endpackage

// File: rtl/wt_ctrl.sv
module wt_ctrl
  import wt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [2:0]       mode,
  input  logic [1:0]       comB,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dirUp,
  input  logic [CNT_W-1:0] actA,
  input  logic [CNT_W-1:0] actB,
  output wtStrobe_t        strb,
  output logic [CNT_W-1:0] topVal,
  output logic             pinEn
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic isPhase, isFast, topFromA, atTop, matchB;
  logic [CNT_W-1:0] cntInc;

  assign cntInc = cnt + ONE;

  always_comb begin
    isPhase  = (mode == MODE_PC_FF) || (mode == MODE_PC_A);
    isFast   = (mode == MODE_FAST_FF) || (mode == MODE_FAST_A);
    topFromA = (mode == MODE_CTC) || (mode == MODE_PC_A) || (mode == MODE_FAST_A);
    topVal   = topFromA ? actA : MAXV;
    atTop    = (cnt == topVal);
    matchB   = (cnt == actB);

    strb           = '0;
    strb.cntOp     = CNT_INC;
    strb.dirNext   = 1'b1;
    strb.immediate = !(isPhase || isFast);
    strb.loadAct   = strb.immediate || atTop;
    strb.pinOp     = PIN_KEEP;

    // counting sequence
    if (isPhase) begin
      if (topVal == '0) begin
        strb.cntOp = CNT_HOLD;
      end else if (dirUp || cnt == '0) begin
        strb.cntOp   = CNT_INC;
        strb.dirNext = (cntInc != topVal);
      end else begin
        strb.cntOp   = CNT_DEC;
        strb.dirNext = (cnt == ONE);
      end
    end else if (isFast || mode == MODE_CTC) begin
      strb.cntOp = atTop ? CNT_ZERO : CNT_INC;
    end

    // overflow point
    if (isPhase)                  strb.setFlag = !dirUp && (cnt == ONE) && (topVal != '0);
    else if (mode == MODE_FAST_A) strb.setFlag = atTop;
    else                          strb.setFlag = (cnt == MAXV);

    // waveform action
    if (isPhase) begin
      if (comB[1]) begin
        if (actB == topVal) begin
          if (atTop) strb.pinOp = comB[0] ? PIN_CLR : PIN_SET;
        end else if (matchB) begin
          if (dirUp) strb.pinOp = comB[0] ? PIN_SET : PIN_CLR;
          else       strb.pinOp = comB[0] ? PIN_CLR : PIN_SET;
        end
      end
    end else if (isFast) begin
      if (comB[1]) begin
        if (atTop)       strb.pinOp = comB[0] ? PIN_CLR : PIN_SET;
        else if (matchB) strb.pinOp = comB[0] ? PIN_SET : PIN_CLR;
      end
    end else if (matchB) begin
      case (comB)
        2'b01:   strb.pinOp = PIN_TGL;
        2'b10:   strb.pinOp = PIN_CLR;
        2'b11:   strb.pinOp = PIN_SET;
        default: strb.pinOp = PIN_KEEP;
      endcase
    end

    pinEn = (comB != 2'b00) && !((isPhase || isFast) && comB == 2'b01);
  end
endmodule

// File: rtl/wt_datapath.sv
module wt_datapath
  import wt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  wtStrobe_t         strb,
  output logic [CNT_W-1:0]  cnt,
  output logic              dirUp,
  output logic [2:0]        mode,
  output logic [1:0]        comB,
  output logic [CNT_W-1:0]  actA,
  output logic [CNT_W-1:0]  actB,
  output logic              wfOut,
  output logic              ovfFlag
);
  logic [CNT_W-1:0] bufA, bufB;
  logic wrCtrlA, wrCtrlB, wrA, wrB, wrFlags;

  assign wrCtrlA = wrEn && (wrAddr == ADDR_W'(ADDR_CTRLA));
  assign wrCtrlB = wrEn && (wrAddr == ADDR_W'(ADDR_CTRLB));
  assign wrA     = wrEn && (wrAddr == ADDR_W'(ADDR_CMPA));
  assign wrB     = wrEn && (wrAddr == ADDR_W'(ADDR_CMPB));
  assign wrFlags = wrEn && (wrAddr == ADDR_W'(ADDR_FLAGS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= '0;
      comB    <= '0;
      bufA    <= '0;
      bufB    <= '0;
      actA    <= '0;
      actB    <= '0;
      cnt     <= '0;
      dirUp   <= 1'b1;
      wfOut   <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (wrCtrlA) begin
        mode[1:0] <= wrData[1:0];
        comB      <= wrData[5:4];
      end
      if (wrCtrlB) mode[2] <= wrData[0];

      if (wrA) bufA <= wrData;
      if (wrB) bufB <= wrData;
      if (wrA && strb.immediate) actA <= wrData;
      else if (strb.loadAct)     actA <= bufA;
      if (wrB && strb.immediate) actB <= wrData;
      else if (strb.loadAct)     actB <= bufB;

      case (strb.cntOp)
        CNT_INC:  cnt <= cnt + 1'b1;
        CNT_DEC:  cnt <= cnt - 1'b1;
        CNT_ZERO: cnt <= '0;
        default:  cnt <= cnt;
      endcase
      dirUp <= strb.dirNext;

      if (strb.setFlag)             ovfFlag <= 1'b1;
      else if (wrFlags && wrData[0]) ovfFlag <= 1'b0;

      case (strb.pinOp)
        PIN_SET: wfOut <= 1'b1;
        PIN_CLR: wfOut <= 1'b0;
        PIN_TGL: wfOut <= !wfOut;
        default: wfOut <= wfOut;
      endcase
    end
  end
endmodule

// File: rtl/wave_timer8.sv
module wave_timer8
  import wt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic              wfOut,
  output logic              wfOutEn,
  output logic              ovfFlag
);
  wtStrobe_t        strb;
  logic [CNT_W-1:0] cnt, actA, actB, topVal;
  logic [2:0]       mode;
  logic [1:0]       comB;
  logic             dirUp;

  wt_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .mode(mode), .comB(comB), .cnt(cnt), .dirUp(dirUp),
    .actA(actA), .actB(actB), .strb(strb), .topVal(topVal), .pinEn(wfOutEn)
  );

  wt_datapath #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .cnt(cnt), .dirUp(dirUp), .mode(mode), .comB(comB),
    .actA(actA), .actB(actB), .wfOut(wfOut), .ovfFlag(ovfFlag)
  );
endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [CNT_W-1:0]  wrData,
  input logic [2:0]        mode,
  input logic [1:0]        comB,
  input logic [CNT_W-1:0]  cnt,
  input logic              dirUp,
  input logic [CNT_W-1:0]  actA,
  input logic [CNT_W-1:0]  topVal,
  input logic              wfOut,
  input logic              wfOutEn,
  input logic              ovfFlag
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    mode == 3'd0 |=> cnt == CNT_W'($past(cnt) + 1'b1));

  assert_ctc_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd2 && cnt == actA) |=> cnt == '0);

  assert_fast_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd3 && comB == 2'b10 && cnt == MAXV) |=> wfOut);

  assert_phase_turn_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd1 && dirUp && cnt == MAXV - 1'b1) |=> (cnt == MAXV && !dirUp));

  assert_phase_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == 3'd1 || mode == 3'd5) && !dirUp && cnt == CNT_W'(1) && topVal != '0) |=> ovfFlag);

  assert_buffer_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == 3'd1 || mode == 3'd5) && cnt != topVal) |=> $stable(actA));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(wrEn && wrAddr == ADDR_W'(4) && wrData[0])) |=> ovfFlag);

  assert_en_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    comB == 2'b00 |-> !wfOutEn);
endmodule

bind wave_timer8 wt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .mode(mode), .comB(comB), .cnt(cnt), .dirUp(dirUp), .actA(actA),
  .topVal(topVal), .wfOut(wfOut), .wfOutEn(wfOutEn), .ovfFlag(ovfFlag)
);

// File: tb/test_wave_timer8.sv
module test_wave_timer8;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       wfOut, wfOutEn, ovfFlag;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // reference model state
  int mCnt, mUp, mMode, mCom, mBufA, mBufB, mActA, mActB, mPin, mFlag;

  always #10 clk = !clk;

  wave_timer8 i_wave_timer8 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wfOut(wfOut), .wfOutEn(wfOutEn), .ovfFlag(ovfFlag)
  );

  function automatic bit isPwm(int m);
    return (m == 1 || m == 5 || m == 3 || m == 7);
  endfunction

  function automatic int expEn();
    if (mCom == 0) return 0;
    if (mCom == 1 && isPwm(mMode)) return 0;
    return 1;
  endfunction

  task automatic checkVal(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void modelReset();
    mCnt = 0; mUp = 1; mMode = 0; mCom = 0;
    mBufA = 0; mBufB = 0; mActA = 0; mActB = 0; mPin = 0; mFlag = 0;
  endfunction

  function automatic void modelEdge(bit we, int a, int d);
    int top, nCnt, nUp, nPin, nFlag;
    bit ph, fa, imm, load, match;
    top = (mMode == 2 || mMode == 5 || mMode == 7) ? mActA : 255;
    ph  = (mMode == 1 || mMode == 5);
    fa  = (mMode == 3 || mMode == 7);
    imm = !ph && !fa;
    nUp = 1;
    if (ph) begin
      if (top == 0) nCnt = mCnt;
      else if (mUp == 1 || mCnt == 0) begin nCnt = (mCnt + 1) % 256; nUp = (nCnt != top); end
      else begin nCnt = mCnt - 1; nUp = (nCnt == 0); end
    end else if (mMode == 2 || fa) nCnt = (mCnt == top) ? 0 : (mCnt + 1) % 256;
    else nCnt = (mCnt + 1) % 256;

    nFlag = mFlag;
    if (we && a == 4 && d[0]) nFlag = 0;
    if (ph) begin if (mUp == 0 && mCnt == 1 && top != 0) nFlag = 1; end
    else if (mMode == 7) begin if (mCnt == top) nFlag = 1; end
    else if (mCnt == 255) nFlag = 1;

    nPin = mPin;
    match = (mCnt == mActB);
    if (ph) begin
      if (mCom >= 2) begin
        if (mActB == top) begin
          if (mCnt == top) nPin = (mCom == 3) ? 0 : 1;
        end else if (match) begin
          if (mUp == 1) nPin = (mCom == 3) ? 1 : 0;
          else          nPin = (mCom == 3) ? 0 : 1;
        end
      end
    end else if (fa) begin
      if (mCom >= 2) begin
        if (mCnt == top) nPin = (mCom == 3) ? 0 : 1;
        else if (match)  nPin = (mCom == 3) ? 1 : 0;
      end
    end else if (match) begin
      if (mCom == 1) nPin = 1 - mPin;
      else if (mCom == 2) nPin = 0;
      else if (mCom == 3) nPin = 1;
    end

    load = imm || ((ph || fa) && mCnt == top);
    if (we && a == 2 && imm) mActA = d; else if (load) mActA = mBufA;
    if (we && a == 3 && imm) mActB = d; else if (load) mActB = mBufB;
    if (we && a == 2) mBufA = d;
    if (we && a == 3) mBufB = d;
    if (we && a == 0) begin mMode = (mMode & 4) | (d & 3); mCom = (d >> 4) & 3; end
    if (we && a == 1) mMode = (mMode & 3) | ((d & 1) << 2);
    mCnt = nCnt; mUp = nUp; mPin = nPin; mFlag = nFlag;
  endfunction

  task automatic step(bit we, int a, int d);
    wrEn = we; wrAddr = a[2:0]; wrData = d[7:0];
    @(posedge clk);
    modelEdge(we, a, d);
    @(negedge clk);
    wrEn = 1'b0;
    checkVal(curReq, "wfOut", int'(wfOut), mPin);
    checkVal(curReq, "wfOutEn", int'(wfOutEn), expEn());
    checkVal(curReq, "ovfFlag", int'(ovfFlag), mFlag);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic doReset();
    wrEn = 1'b0;
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, first flag after 256 edges
    doReset();
    checkVal("R1", "wfOut", int'(wfOut), 0);
    checkVal("R1", "wfOutEn", int'(wfOutEn), 0);
    checkVal("R1", "ovfFlag", int'(ovfFlag), 0);
    run(255);
    checkVal("R1", "ovfFlag before 256th edge", int'(ovfFlag), 0);
    curReq = "R3";
    run(1);
    checkVal("R3", "ovfFlag at 256th edge", int'(ovfFlag), 1);
    run(300);

    // R9: write 0 leaves the flag, write 1 clears it
    curReq = "R9";
    step(1, 4, 0);
    checkVal("R9", "ovfFlag after writing 0", int'(ovfFlag), 1);
    step(1, 4, 1);
    checkVal("R9", "ovfFlag after writing 1", int'(ovfFlag), 0);
    run(4);

    // R11: non-PWM compare actions
    doReset();
    curReq = "R11";
    step(1, 3, 8'h10);
    step(1, 0, 8'h10);
    run(600);
    step(1, 0, 8'h20);
    run(300);
    step(1, 0, 8'h30);
    run(300);

    // R2: reserved ctrlA bits and reserved modes
    doReset();
    curReq = "R2";
    step(1, 3, 8'h05);
    step(1, 0, 8'h1C);
    run(300);
    step(1, 1, 8'h01);
    run(300);
    checkVal("R2", "wfOutEn in mode 4 comB=01", int'(wfOutEn), 1);
    step(1, 0, 8'h12);
    run(300);

    // R4: CTC wrap at compare A, no flag below 0xFF
    doReset();
    curReq = "R4";
    step(1, 2, 8'h40);
    step(1, 3, 8'h20);
    step(1, 0, 8'h12);
    run(400);
    checkVal("R4", "ovfFlag with TOP 0x40", int'(ovfFlag), 0);
    step(1, 2, 8'hFF);
    run(600);

    // R5: fast PWM with TOP 0xFF
    doReset();
    curReq = "R5";
    step(1, 3, 8'h80);
    step(1, 0, 8'h23);
    run(600);
    step(1, 0, 8'h33);
    run(300);
    curReq = "R10";
    step(1, 0, 8'h13);
    checkVal("R10", "wfOutEn fast comB=01", int'(wfOutEn), 0);
    step(1, 0, 8'h03);
    checkVal("R10", "wfOutEn comB=00", int'(wfOutEn), 0);
    run(20);

    // R12 / R8: fast PWM with TOP from compare A, buffered writes
    doReset();
    curReq = "R12";
    step(1, 2, 8'h60);
    step(1, 3, 8'h30);
    step(1, 1, 8'h01);
    step(1, 0, 8'h23);
    run(150);
    curReq = "R8";
    step(1, 3, 8'h10);
    run(200);
    step(1, 2, 8'h20);
    run(300);

    // R6 / R8 / R7: phase-correct with TOP 0xFF
    doReset();
    curReq = "R6";
    step(1, 3, 8'h40);
    step(1, 0, 8'h21);
    run(1100);
    curReq = "R8";
    step(1, 3, 8'hA0);
    run(1100);
    curReq = "R7";
    step(1, 0, 8'h31);
    run(600);
    curReq = "R10";
    step(1, 0, 8'h11);
    checkVal("R10", "wfOutEn phase comB=01", int'(wfOutEn), 0);

    // R7: phase-correct with TOP from compare A, compare B at TOP and at 0
    doReset();
    curReq = "R7";
    step(1, 2, 8'h50);
    step(1, 3, 8'h50);
    step(1, 1, 8'h01);
    step(1, 0, 8'h21);
    run(500);
    step(1, 3, 8'h00);
    run(500);
    step(1, 3, 8'h50);
    step(1, 0, 8'h31);
    run(400);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule